// File: doc/BRIEF.md
# Instruction Fetch Next-Address Unit

This block keeps the program counter of a single-cycle processor and works out where the following instruction is fetched from. Instructions are one 32-bit word each and always sit on word boundaries, so the two low address bits are never stored. The register holds only a 30-bit word index, and the byte address sent to instruction memory is that index with two zero bits appended.

On every rising clock edge the word index does one of two things. It steps forward by one word, or it jumps relative to the following word by a signed 16-bit word offset. The jump is taken only when the decoder flags a compare-and-branch instruction and the datapath reports that the two compared registers are equal. A synchronous reset returns the index to zero. The branch offset is already counted in words, so it is added without any shift.

Top module: `nextpc_unit`

## Requirements
- R1: A clock edge with `rst` high makes `fetch_addr` equal to 0x00000000 from that edge on.
- R2: Bits [1:0] of `fetch_addr` are always zero.
- R3: A clock edge with `rst` low and `br_sel` low adds 4 to `fetch_addr`.
- R4: A clock edge with `br_sel` high and `cond_eq` low also adds 4 to `fetch_addr`. A branch whose comparison fails falls through.
- R5: `cond_eq` has no effect while `br_sel` is low.
- R6: A clock edge with `br_sel` and `cond_eq` both high makes `fetch_addr` equal to old `fetch_addr` + 4 + 4 × `br_imm`, with `br_imm` read as a signed two's-complement word count.
- R7: Bit 15 of `br_imm` is the sign bit. Offsets with bit 15 set move the address backward. For example, 0xFFFF returns to the same address.
- R8: Address arithmetic wraps modulo 2^32. The word index wraps modulo 2^30, in both directions.
- R9: `rst` takes priority over a taken branch on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the word index updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| br_imm | input | 16 | Signed branch offset in words |
| br_sel | input | 1 | Decoder flag: the current instruction is compare-and-branch |
| cond_eq | input | 1 | Datapath flag: the compared registers are equal |
| fetch_addr | output | 32 | Byte address of the current instruction |

## Verification
Directed steps first try each of the four combinations of `br_sel` and `cond_eq`. This separates the taken path from the two kinds of fall-through and shows that the equality flag alone does nothing. Offsets of zero, -1 and the extreme positive and negative values separate a correct sign extension from zero extension, and show whether the word offset gets a spurious shift. A backward branch from address zero and a sequential step from the top word exercise wrap-around in both directions. A long random mix then compares every edge with a reference model, and includes resets that coincide with taken branches.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;
   typedef enum logic {
      NPC_SEQ    = 1'b0,
      NPC_BRANCH = 1'b1
   } npc_src_e;
endpackage

// File: rtl/nextpc_offset_ext.sv
module nextpc_offset_ext #(
   parameter int IMM_W  = 16,
   parameter int WORD_W = 30
) (
   input  logic [IMM_W-1:0]  imm,
   output logic [WORD_W-1:0] offset
);
   localparam int PAD_W = WORD_W - IMM_W;

   generate
      if (PAD_W > 0) begin : g_extend
         assign offset = {{PAD_W{imm[IMM_W-1]}}, imm};
      end else begin : g_pass
         assign offset = imm[WORD_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/nextpc_select.sv
module nextpc_select
   import nextpc_pkg::*;
#(
   parameter int WORD_W = 30
) (
   input  logic [WORD_W-1:0] cur_word,
   input  logic [WORD_W-1:0] offset,
   input  logic              br_sel,
   input  logic              cond_eq,
   output logic [WORD_W-1:0] next_word
);
   logic [WORD_W-1:0] seq_word;
   logic [WORD_W-1:0] tgt_word;
   npc_src_e          src;

   assign seq_word = cur_word + WORD_W'(1);
   assign tgt_word = seq_word + offset;

   always_comb begin
      src = (br_sel && cond_eq) ? NPC_BRANCH : NPC_SEQ;
      unique case (src)
         NPC_BRANCH: next_word = tgt_word;
         default:    next_word = seq_word;
      endcase
   end
endmodule

// File: rtl/nextpc_word_reg.sv
module nextpc_word_reg #(
   parameter int WORD_W = 30
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [WORD_W-1:0] d,
   output logic [WORD_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= d;
   end
endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit #(
   parameter int ADDR_W     = 32,
   parameter int ALIGN_BITS = 2,
   parameter int IMM_W      = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [IMM_W-1:0]  br_imm,
   input  logic              br_sel,
   input  logic              cond_eq,
   output logic [ADDR_W-1:0] fetch_addr
);
   localparam int WORD_W = ADDR_W - ALIGN_BITS;

   initial begin
      if (ALIGN_BITS < 1 || ALIGN_BITS >= ADDR_W)
         $fatal(1, "nextpc_unit: ALIGN_BITS out of range");
      if (IMM_W < 1 || IMM_W > WORD_W)
         $fatal(1, "nextpc_unit: IMM_W must fit in the word index");
   end

   logic [WORD_W-1:0] word_q;
   logic [WORD_W-1:0] word_d;
   logic [WORD_W-1:0] offset;

   nextpc_offset_ext #(.IMM_W(IMM_W), .WORD_W(WORD_W)) u_ext (
      .imm    (br_imm),
      .offset (offset)
   );

   nextpc_select #(.WORD_W(WORD_W)) u_sel (
      .cur_word  (word_q),
      .offset    (offset),
      .br_sel    (br_sel),
      .cond_eq   (cond_eq),
      .next_word (word_d)
   );

   nextpc_word_reg #(.WORD_W(WORD_W)) u_reg (
      .clk (clk),
      .rst (rst),
      .d   (word_d),
      .q   (word_q)
   );

   assign fetch_addr = {word_q, {ALIGN_BITS{1'b0}}};
endmodule

// File: rtl/nextpc_unit_chk.sv
module nextpc_unit_chk #(
   parameter int ADDR_W     = 32,
   parameter int ALIGN_BITS = 2,
   parameter int IMM_W      = 16
) (
   input logic              clk,
   input logic              rst,
   input logic [IMM_W-1:0]  br_imm,
   input logic              br_sel,
   input logic              cond_eq,
   input logic [ADDR_W-1:0] fetch_addr
);
   localparam int PAD_W = ADDR_W - ALIGN_BITS - IMM_W;
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << ALIGN_BITS;

   p_reset_zero_r1: assert property (@(posedge clk)
      rst |=> fetch_addr == '0);

   p_aligned_r2: assert property (@(posedge clk) disable iff (rst)
      fetch_addr[ALIGN_BITS-1:0] == '0);

   // R3, R4, R5: every non-taken edge advances one word
   p_sequential_r3: assert property (@(posedge clk) disable iff (rst)
      !(br_sel && cond_eq) |=> fetch_addr == $past(fetch_addr) + STEP);

   // R6, R7, R8: taken edge adds the signed word offset after the step
   p_taken_r6: assert property (@(posedge clk) disable iff (rst)
      (br_sel && cond_eq) |=> fetch_addr == $past(fetch_addr) + STEP
         + {{PAD_W{$past(br_imm[IMM_W-1])}}, $past(br_imm), {ALIGN_BITS{1'b0}}});
endmodule

bind nextpc_unit nextpc_unit_chk #(
   .ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS), .IMM_W(IMM_W)
) u_chk (
   .clk(clk), .rst(rst), .br_imm(br_imm), .br_sel(br_sel),
   .cond_eq(cond_eq), .fetch_addr(fetch_addr)
);

// File: tb/tb_nextpc_unit.sv
`timescale 1ns/1ps
module tb_nextpc_unit;
   logic        clk = 1'b0;
   logic        rst;
   logic [15:0] br_imm;
   logic        br_sel;
   logic        cond_eq;
   logic [31:0] fetch_addr;

   int checks = 0;
   int fails  = 0;
   logic [31:0] model;

   nextpc_unit dut (
      .clk(clk), .rst(rst), .br_imm(br_imm), .br_sel(br_sel),
      .cond_eq(cond_eq), .fetch_addr(fetch_addr)
   );

   always #2.5 clk = ~clk;

   function automatic logic [31:0] expect_next(input logic [31:0] cur,
         input logic r, input logic s, input logic e, input logic [15:0] imm);
      logic [31:0] off;
      off = {{14{imm[15]}}, imm, 2'b00};
      if (r)          return 32'h0;
      else if (s && e) return cur + 32'd4 + off;
      else             return cur + 32'd4;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(input logic r, input logic s, input logic e,
                       input logic [15:0] imm, input string req);
      @(negedge clk);
      rst = r; br_sel = s; cond_eq = e; br_imm = imm;
      model = expect_next(model, r, s, e, imm);
      @(posedge clk);
      #1;
      check(req, fetch_addr, model);
      check("R2", {30'd0, fetch_addr[1:0]}, 32'h0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      rst = 1'b1; br_sel = 1'b0; cond_eq = 1'b0; br_imm = '0;
      model = '0;
      step(1'b1, 1'b0, 1'b0, 16'h0, "R1 reset");
      step(1'b0, 1'b0, 1'b0, 16'h0, "R3 sequential");
      step(1'b0, 1'b0, 1'b0, 16'h0, "R3 sequential");
      step(1'b0, 1'b1, 1'b0, 16'h0010, "R4 not-equal falls through");
      step(1'b0, 1'b0, 1'b1, 16'h0010, "R5 eq ignored without select");
      step(1'b0, 1'b1, 1'b1, 16'h0010, "R6 taken forward");
      step(1'b0, 1'b1, 1'b1, 16'h0000, "R6 zero offset");
      step(1'b0, 1'b1, 1'b1, 16'hFFFF, "R7 offset -1 stays");
      step(1'b0, 1'b1, 1'b1, 16'hFFF0, "R7 backward");
      step(1'b0, 1'b1, 1'b1, 16'h7FFF, "R7 max positive");
      step(1'b0, 1'b1, 1'b1, 16'h8000, "R7 max negative");
      step(1'b1, 1'b1, 1'b1, 16'h1234, "R9 reset beats branch");
      step(1'b0, 1'b1, 1'b1, 16'hFFFE, "R8 wrap below zero");
      check("R8 top word", fetch_addr, 32'hFFFF_FFFC);
      step(1'b0, 1'b0, 1'b0, 16'h0, "R8 wrap above top");
      check("R8 back to zero", fetch_addr, 32'h0);

      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < 400; i++) begin
         logic r, s, e;
         logic [15:0] imm;
         r   = ($urandom % 25) == 0;
         s   = $urandom % 2;
         e   = $urandom % 2;
         imm = 16'($urandom);
         step(r, s, e, imm, r ? "R9 random reset" : ((s && e) ? "R6 random taken" : "R3 random seq"));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule